// File: doc/BRIEF.md
# Ladder Logic Scan Engine

This block is a small programmable controller core. It executes a stored relay-ladder program over a 16-bit discrete input word and a 16-bit discrete output word, and it repeats the same scan cycle for as long as it is not held in program mode. Each scan solves every rung in program order, one instruction per clock. After the end instruction, one I/O update cycle copies the output image onto the output pins and samples the input pins into the input image. Because the rungs read only the image registers, the program always sees a consistent snapshot of the inputs. The pins change only at the update cycle.

The program memory holds 8-bit instructions: contacts that examine a bit for 1 or for 0, branch open, next branch and branch close, coils, and end. Contacts can examine bits of either the input image or the output image. The memory is loaded through a plain address, data and write-enable port while the core is in program mode. Run mode drives the outputs from the program. Test mode runs the same scans but keeps every output pin at 0. The core measures each scan in clock cycles and keeps both the most recent value and the largest value seen since reset.

Top module: `ladder_scan_core`

## Requirements
- R1: `mode` uses this encoding: 00 is program, 01 is run, 10 is test, and 11 is treated as program. In program mode no scan runs, and `out_pins` reads 0 from the next clock edge onward.
- R2: A write on the program port stores `prog_data` at `prog_addr` only when `prog_we` is 1 in program mode. In run or test mode the write is ignored.
- R3: Instruction encoding. Bits [7:5] hold the opcode: 0 examine-on, 1 examine-off, 2 branch open, 3 next branch, 4 branch close, 5 coil, 6 no-op, 7 end. Bit 4 selects the image: 0 is the input image and 1 is the output image. Bits [3:0] give the bit index, 0 to 15 (octal 00 to 17).
- R4: An examine-on contact passes when its bit is 1. An examine-off contact passes when its bit is 0. Contacts placed in series are ANDed.
- R5: The paths between branch open and branch close, separated by next branch, are ORed. That OR is then ANDed with the contacts before the branch. Branches nest one level deep.
- R6: A coil writes the current rung value to its output-image bit. Several coils in a row share one rung. The first contact after a coil starts a new rung from true, so a coil that no contact precedes writes 1.
- R7: When several coils in one scan write the same bit, the value written by the last of them reaches the pin.
- R8: Inputs are sampled only at the I/O update, and once when the core leaves program mode. `out_pins` changes only at the I/O update that follows end. A contact on an output-image bit sees the value that an earlier coil wrote in the same scan.
- R9: Test mode solves scans exactly as run mode does, with the same scan time, but every I/O update drives `out_pins` to 0.
- R10: `last_scan` equals the number of instructions executed, end included, plus 1 for the I/O update. `max_scan` holds the largest `last_scan` since reset. If the last memory address executes without an end, the scan ends there.
- R11: After reset, `out_pins`, `last_scan` and `max_scan` are 0 and every memory word holds the end instruction (8'hE0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Operating mode (R1 encoding) |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | AW (5) | Program memory write address |
| prog_data | input | 8 | Instruction word to store |
| in_pins | input | 16 | Discrete input terminals |
| out_pins | output | 16 | Discrete output terminals |
| last_scan | output | CNT_W (16) | Duration of the last completed scan, in cycles |
| max_scan | output | CNT_W (16) | Longest scan since reset, in cycles |

## Verification
The assertions assume that `mode` changes only between clock edges and that reset is held long enough for the program memory to fill with end words. They also assume that a scan never runs past the saturation limit of the cycle counter, so the recorded times keep growing with the program length. The bench changes `mode`, `in_pins` and the program port only on falling edges. It loads programs only in program mode, except for the one deliberate write that checks the ignored case. Every program it loads is shorter than the memory depth, or fills it exactly, so the counter always stays far below its limit.

// File: rtl/ladder_pkg.sv
package ladder_pkg;
   typedef enum logic [2:0] {
      OP_XON = 3'd0,
      OP_XOFF = 3'd1,
      OP_BOPEN = 3'd2,
      OP_BNEXT = 3'd3,
      OP_BCLOSE = 3'd4,
      OP_COIL = 3'd5,
      OP_NOP = 3'd6,
      OP_END = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      MD_PROG = 2'd0,
      MD_RUN = 2'd1,
      MD_TEST = 2'd2,
      MD_HALT = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SOLVE = 2'd1,
      ST_IO = 2'd2
   } scan_st_e;

   typedef struct packed {
      op_e        op;
      logic       tbl;
      logic [3:0] idx;
   } instr_t;

   localparam logic [7:0] END_WORD = 8'hE0;
endpackage

// File: rtl/ladder_prog_mem.sv
module ladder_prog_mem #(
   parameter int DEPTH = 32,
   parameter int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [DEPTH-1:0][7:0] words_q;
   logic [DEPTH-1:0]      wsel;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_wsel
      assign wsel[gi] = we && (waddr == AW'(gi));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) words_q[i] <= ladder_pkg::END_WORD;
      end else begin
         for (int i = 0; i < DEPTH; i++)
            if (wsel[i]) words_q[i] <= wdata;
      end
   end

   assign rdata = words_q[raddr];
endmodule

// File: rtl/ladder_rung_solver.sv
module ladder_rung_solver #(
   parameter int IMG_W = 16,
   parameter int IDX_W = $clog2(IMG_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   input  logic [7:0]       instr,
   input  logic [IMG_W-1:0] in_img,
   input  logic [IMG_W-1:0] out_img,
   output logic             coil_we,
   output logic [IDX_W-1:0] coil_idx,
   output logic             coil_val
);
   import ladder_pkg::*;

   instr_t ins;
   logic   acc_q, or_q, pre_q, fresh_q;
   logic   acc_d, or_d, pre_d, fresh_d;
   logic   bit_v, base;

   assign ins   = instr_t'(instr);
   assign bit_v = ins.tbl ? out_img[ins.idx] : in_img[ins.idx];
   assign base  = fresh_q ? 1'b1 : acc_q;

   always_comb begin
      acc_d   = acc_q;
      or_d    = or_q;
      pre_d   = pre_q;
      fresh_d = fresh_q;
      unique case (ins.op)
         OP_XON: begin
            acc_d   = base & bit_v;
            fresh_d = 1'b0;
         end
         OP_XOFF: begin
            acc_d   = base & ~bit_v;
            fresh_d = 1'b0;
         end
         OP_BOPEN: begin
            pre_d   = base;
            or_d    = 1'b0;
            acc_d   = base;
            fresh_d = 1'b0;
         end
         OP_BNEXT: begin
            or_d  = or_q | acc_q;
            acc_d = pre_q;
         end
         OP_BCLOSE: acc_d = or_q | acc_q;
         OP_COIL: fresh_d = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= 1'b1;
         or_q    <= 1'b0;
         pre_q   <= 1'b1;
         fresh_q <= 1'b0;
      end else if (start) begin
         acc_q   <= 1'b1;
         or_q    <= 1'b0;
         pre_q   <= 1'b1;
         fresh_q <= 1'b0;
      end else if (step) begin
         acc_q   <= acc_d;
         or_q    <= or_d;
         pre_q   <= pre_d;
         fresh_q <= fresh_d;
      end
   end

   assign coil_we  = step && (ins.op == OP_COIL);
   assign coil_idx = ins.idx;
   assign coil_val = acc_q;
endmodule

// File: rtl/ladder_scan_timer.sv
module ladder_scan_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic             done,
   output logic [CNT_W-1:0] last_q,
   output logic [CNT_W-1:0] max_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q, total;

   assign total = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= '0;
         max_q  <= '0;
      end else begin
         if (start) cnt_q <= '0;
         else if (tick) cnt_q <= total;
         if (done) begin
            last_q <= total;
            if (total > max_q) max_q <= total;
         end
      end
   end
endmodule

// File: rtl/ladder_scan_core.sv
module ladder_scan_core #(
   parameter int DEPTH = 32,
   parameter int IMG_W = 16,
   parameter int CNT_W = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int IDX_W = $clog2(IMG_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             prog_we,
   input  logic [AW-1:0]    prog_addr,
   input  logic [7:0]       prog_data,
   input  logic [IMG_W-1:0] in_pins,
   output logic [IMG_W-1:0] out_pins,
   output logic [CNT_W-1:0] last_scan,
   output logic [CNT_W-1:0] max_scan
);
   import ladder_pkg::*;

   if (IMG_W != 16) begin : g_chk_img
      $error("IMG_W must be 16 to match the 4-bit index field");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (CNT_W < 4) begin : g_chk_cnt
      $error("CNT_W must be at least 4");
   end

   localparam logic [AW-1:0] LAST_PC = AW'(DEPTH - 1);

   mode_e            md;
   scan_st_e         state_q;
   logic [AW-1:0]    pc_q;
   logic [IMG_W-1:0] in_img, out_img, out_q;
   logic [7:0]       cur_word;
   logic             halted, solving, io_phase, idle_phase, start_scan;
   logic             coil_we, coil_val;
   logic [IDX_W-1:0] coil_idx;
   instr_t           cur;

   assign md         = mode_e'(mode);
   assign halted     = (md == MD_PROG) || (md == MD_HALT);
   assign solving    = !halted && (state_q == ST_SOLVE);
   assign io_phase   = (state_q == ST_IO);
   assign idle_phase = (state_q == ST_IDLE);
   assign start_scan = !halted && (idle_phase || io_phase);
   assign cur        = instr_t'(cur_word);

   ladder_prog_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(prog_we && halted), .waddr(prog_addr),
      .wdata(prog_data), .raddr(pc_q), .rdata(cur_word)
   );

   ladder_rung_solver #(.IMG_W(IMG_W), .IDX_W(IDX_W)) u_solver (
      .clk(clk), .rst_n(rst_n), .start(start_scan), .step(solving),
      .instr(cur_word), .in_img(in_img), .out_img(out_img),
      .coil_we(coil_we), .coil_idx(coil_idx), .coil_val(coil_val)
   );

   ladder_scan_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start_scan), .tick(solving),
      .done(!halted && io_phase), .last_q(last_scan), .max_q(max_scan)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         in_img  <= '0;
         out_img <= '0;
         out_q   <= '0;
      end else if (halted) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         out_img <= '0;
         out_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               in_img  <= in_pins;
               pc_q    <= '0;
               state_q <= ST_SOLVE;
            end
            ST_SOLVE: begin
               if (coil_we) out_img[coil_idx] <= coil_val;
               if (cur.op == OP_END || pc_q == LAST_PC) state_q <= ST_IO;
               else pc_q <= pc_q + 1'b1;
            end
            default: begin
               out_q   <= (md == MD_TEST) ? '0 : out_img;
               in_img  <= in_pins;
               pc_q    <= '0;
               state_q <= ST_SOLVE;
            end
         endcase
      end
   end

   assign out_pins = out_q;
endmodule

// File: rtl/ladder_scan_core_chk.sv
module ladder_scan_core_chk #(
   parameter int IMG_W = 16,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic [IMG_W-1:0] out_pins,
   input logic [IMG_W-1:0] in_img,
   input logic [CNT_W-1:0] last_scan,
   input logic [CNT_W-1:0] max_scan,
   input logic             io_phase,
   input logic             idle_phase
);
   logic active;
   assign active = (mode == 2'd1) || (mode == 2'd2);

   assert_prog_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> out_pins == '0);

   assert_test_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (io_phase && mode == 2'd2) |=> out_pins == '0);

   assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !io_phase) |=> $stable(out_pins));

   assert_in_snap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !io_phase && !idle_phase) |=> $stable(in_img));

   assert_max_ge_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
      max_scan >= last_scan);

   assert_max_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> max_scan >= $past(max_scan));

   assert_last_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (io_phase && active) |=> last_scan >= CNT_W'(2));
endmodule

bind ladder_scan_core ladder_scan_core_chk #(.IMG_W(IMG_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .out_pins(out_pins), .in_img(in_img),
   .last_scan(last_scan), .max_scan(max_scan), .io_phase(io_phase),
   .idle_phase(idle_phase)
);

// File: tb/ladder_scan_core_bench.sv
module ladder_scan_core_bench;
   localparam int DEPTH = 32;
   localparam logic [1:0] M_PROG = 2'd0, M_RUN = 2'd1, M_TEST = 2'd2;
   localparam logic [2:0] XON = 3'd0, XOFF = 3'd1, BOPEN = 3'd2, BNEXT = 3'd3,
                          BCLOSE = 3'd4, COIL = 3'd5, NOP = 3'd6, ENDI = 3'd7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        prog_we = 1'b0;
   logic [4:0]  prog_addr = '0;
   logic [7:0]  prog_data = '0;
   logic [15:0] in_pins = '0;
   logic [15:0] out_pins;
   logic [15:0] last_scan, max_scan;

   int total = 0;
   int bad = 0;
   logic [7:0] prog [DEPTH];
   int plen;

   always #5 clk = ~clk;

   ladder_scan_core u_ladder_scan_core (
      .clk(clk), .rst_n(rst_n), .mode(mode), .prog_we(prog_we),
      .prog_addr(prog_addr), .prog_data(prog_data), .in_pins(in_pins),
      .out_pins(out_pins), .last_scan(last_scan), .max_scan(max_scan)
   );

   function automatic logic [7:0] ins(logic [2:0] op, logic tbl, logic [3:0] idx);
      return {op, tbl, idx};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_prog();
      for (int i = 0; i < DEPTH; i++) prog[i] = ins(ENDI, 1'b0, 4'd0);
      plen = 0;
   endtask

   task automatic add(logic [7:0] w);
      prog[plen] = w;
      plen++;
   endtask

   task automatic load_and_run(logic [1:0] m);
      mode = M_PROG;
      cyc(1);
      for (int i = 0; i < DEPTH; i++) begin
         prog_we = 1'b1; prog_addr = 5'(i); prog_data = prog[i];
         cyc(1);
      end
      prog_we = 1'b0;
      mode = m;
      cyc(4);
   endtask

   task automatic t_reset();
      chk("R11 out after reset", 32'(out_pins), 0);
      chk("R11 last after reset", 32'(last_scan), 0);
      chk("R11 max after reset", 32'(max_scan), 0);
      mode = M_RUN;
      cyc(10);
      chk("R11 memory holds END", 32'(last_scan), 2);
   endtask

   task automatic t_series();
      clear_prog();
      add(ins(XON, 0, 0)); add(ins(XON, 0, 1)); add(ins(XOFF, 0, 2));
      add(ins(COIL, 0, 0)); add(ins(ENDI, 0, 0));
      load_and_run(M_RUN);
      for (int v = 0; v < 8; v++) begin
         in_pins = 16'(v);
         cyc(30);
         chk("R4 R3 series AND", 32'(out_pins[0]),
             32'(v[0] & v[1] & ~v[2]));
      end
      chk("R10 scan time", 32'(last_scan), 6);
   endtask

   task automatic t_branch();
      clear_prog();
      add(ins(XON, 0, 0)); add(ins(BOPEN, 0, 0)); add(ins(XON, 0, 1));
      add(ins(BNEXT, 0, 0)); add(ins(XON, 0, 2)); add(ins(BNEXT, 0, 0));
      add(ins(XOFF, 0, 3)); add(ins(BCLOSE, 0, 0)); add(ins(COIL, 0, 1));
      add(ins(ENDI, 0, 0));
      load_and_run(M_RUN);
      for (int v = 0; v < 16; v++) begin
         in_pins = 16'(v);
         cyc(40);
         chk("R5 branch OR", 32'(out_pins[1]),
             32'(v[0] & (v[1] | v[2] | ~v[3])));
      end
   endtask

   task automatic t_multi_coil();
      clear_prog();
      add(ins(COIL, 0, 9));
      add(ins(XON, 0, 4)); add(ins(COIL, 0, 2)); add(ins(COIL, 0, 3));
      add(ins(XOFF, 0, 4)); add(ins(COIL, 0, 4)); add(ins(ENDI, 0, 0));
      load_and_run(M_RUN);
      for (int v = 0; v < 2; v++) begin
         in_pins = 16'(v) << 4;
         cyc(30);
         chk("R6 shared rung coils", 32'(out_pins[4:2]),
             32'({~v[0], v[0], v[0]}));
         chk("R6 unconditional coil", 32'(out_pins[9]), 1);
      end
   endtask

   task automatic t_dup_coil();
      clear_prog();
      add(ins(XON, 0, 7)); add(ins(COIL, 0, 6));
      add(ins(XOFF, 0, 7)); add(ins(COIL, 0, 6)); add(ins(ENDI, 0, 0));
      load_and_run(M_RUN);
      in_pins = 16'h0080; cyc(30);
      chk("R7 last coil wins (in=1)", 32'(out_pins[6]), 0);
      in_pins = 16'h0000; cyc(30);
      chk("R7 last coil wins (in=0)", 32'(out_pins[6]), 1);
   endtask

   task automatic t_seal_in();
      clear_prog();
      add(ins(BOPEN, 0, 0)); add(ins(XON, 0, 5)); add(ins(BNEXT, 0, 0));
      add(ins(XON, 1, 5)); add(ins(BCLOSE, 0, 0)); add(ins(XOFF, 0, 6));
      add(ins(COIL, 0, 5)); add(ins(ENDI, 0, 0));
      load_and_run(M_RUN);
      cyc(30);
      chk("R8 seal-in idle", 32'(out_pins[5]), 0);
      in_pins = 16'h0020; cyc(30);
      in_pins = 16'h0000; cyc(30);
      chk("R8 output image contact holds", 32'(out_pins[5]), 1);
      in_pins = 16'h0040; cyc(30);
      chk("R8 seal-in released", 32'(out_pins[5]), 0);
      in_pins = 16'h0000;
   endtask

   task automatic t_io_timing();
      clear_prog();
      add(ins(XON, 0, 8)); add(ins(COIL, 0, 7)); add(ins(ENDI, 0, 0));
      load_and_run(M_RUN);
      in_pins = 16'h0000; cyc(20);
      in_pins = 16'h0100;
      cyc(3);
      chk("R8 output waits for I/O update", 32'(out_pins[7]), 0);
      cyc(12);
      chk("R8 output after update", 32'(out_pins[7]), 1);
      chk("R10 short scan time", 32'(last_scan), 4);
   endtask

   task automatic t_test_mode();
      logic [15:0] run_last;
      clear_prog();
      add(ins(XON, 0, 1)); add(ins(COIL, 0, 12)); add(ins(ENDI, 0, 0));
      load_and_run(M_RUN);
      in_pins = 16'h0002; cyc(20);
      chk("R9 run drives output", 32'(out_pins[12]), 1);
      run_last = last_scan;
      mode = M_TEST; cyc(20);
      chk("R9 test holds outputs off", 32'(out_pins), 0);
      chk("R9 test scan time matches", 32'(last_scan), 32'(run_last));
      mode = M_RUN; cyc(20);
      chk("R9 back to run", 32'(out_pins[12]), 1);
   endtask

   task automatic t_prog_port();
      prog_we = 1'b1; prog_addr = 5'd0; prog_data = ins(ENDI, 0, 0);
      cyc(1);
      prog_we = 1'b0;
      cyc(20);
      chk("R2 write ignored in run (output)", 32'(out_pins[12]), 1);
      chk("R2 write ignored in run (scan)", 32'(last_scan), 4);
      mode = 2'd3; cyc(2);
      chk("R1 mode 11 acts as program", 32'(out_pins), 0);
      mode = M_RUN; cyc(20);
      mode = M_PROG; cyc(2);
      chk("R1 program mode output off", 32'(out_pins), 0);
   endtask

   task automatic t_no_end();
      clear_prog();
      for (int i = 0; i < DEPTH; i++) add(ins(NOP, 0, 0));
      load_and_run(M_RUN);
      cyc(80);
      chk("R10 scan ends at last address", 32'(last_scan), 33);
      chk("R10 max tracks longest", 32'(max_scan), 33);
      clear_prog();
      add(ins(ENDI, 0, 0));
      load_and_run(M_RUN);
      cyc(20);
      chk("R10 last after short program", 32'(last_scan), 2);
      chk("R10 max keeps longest", 32'(max_scan), 33);
      rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
      chk("R11 max cleared by reset", 32'(max_scan), 0);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_series();
      t_branch();
      t_multi_coil();
      t_dup_coil();
      t_seal_in();
      t_io_timing();
      t_test_mode();
      t_prog_port();
      t_no_end();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule